// File: doc/BRIEF.md
# Eight-Bit Clocked Serial Port

This block moves one byte at a time over a three-wire synchronous link: a serial data input, a serial data output and a shift clock. The shift clock can be driven out by the block, or it can be taken from a remote master. When the block drives the clock, it derives it from the instruction-cycle rate, which is `CYC_DIV` system clocks long. When the clock comes from outside, the clock pin and the data input are first resynchronised into the system clock domain. Only edges seen while a transfer is running have any effect.

The host presents a byte on `tx_byte` and pulses `start`. The port then exchanges exactly eight bits, most significant bit first. Each received bit is taken on a rising shift-clock edge. Each transmitted bit is put out after a falling edge. When the eighth rising edge has been taken, `busy` drops and `done` is high for one cycle. In that same cycle `rx_byte` shows the received byte. `done` can be wired straight to an interrupt controller. The interface is plain control: there is no back-pressure. A `start` that arrives while `busy` is high is discarded rather than held. `rx_byte` keeps its value until the next transfer completes.

Top module: `sio8_port`

## Requirements
- R1: While reset is held, and right after it is released: `sck_o` is 1, `busy` is 0, `done` is 0, `so` is 0 and `rx_byte` is 0.
- R2: A `start` seen while idle sets `busy` in the next cycle. Each start command moves exactly 8 bits. In internal mode, `done` appears exactly 16·`CYC_DIV` cycles after `busy` rises.
- R3: Input bits are taken from `si` on rising shift-clock edges, the first bit into bit 7 of `rx_byte`. `rx_byte` changes only in a cycle where `done` is high.
- R4: `so` changes only after a falling shift-clock edge. The bits sent are `tx_byte[7]` first, down to `tx_byte[0]`.
- R5: In internal mode (`clk_src`=0), `sck_o` idles high. Each high phase and each low phase lasts `CYC_DIV` system cycles, so one period is two instruction cycles. The first falling edge comes `CYC_DIV` cycles after `busy` rises.
- R6: `sck_oe` is 1 in internal mode and 0 in external mode (`clk_src`=1). In external mode the shift edges come from `sck_i`, and `sck_o` stays at 1.
- R7: In external mode, `sck_i` and `si` pass through a two-flop synchroniser. Edges on `sck_i` while idle change neither `busy`, `done`, `so` nor `rx_byte`.
- R8: A `start` pulse while `busy` is high is ignored. The running transfer keeps its data and its length, and it produces exactly one `done`.
- R9: `done` is high for exactly one cycle per transfer, in the same cycle that `busy` becomes 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_src | input | 1 | 0 = block drives the shift clock, 1 = shift clock taken from `sck_i` |
| start | input | 1 | One-cycle start command, honoured only while idle |
| tx_byte | input | 8 | Byte to send, captured on an accepted start |
| si | input | 1 | Serial data input |
| sck_i | input | 1 | Shift clock from an external master |
| sck_o | output | 1 | Generated shift clock, idle high |
| sck_oe | output | 1 | Output enable for the shift-clock pad |
| so | output | 1 | Serial data output |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse (interrupt request) |
| rx_byte | output | 8 | Last byte received |

## Verification
The bench plays the remote side in both clock modes. It feeds a distinct receive pattern on each falling edge it sees and records `so` just before each rising edge. A design that launched on the wrong edge, or shifted least significant bit first, would return mirrored or shifted bytes. It also times every phase of the generated clock and the distance from start to `done`, which exposes a divider that is off by one or a bit counter that stops at 7 or 9. Directed cases pulse `start` in the middle of a transfer, where a faulty port would reload its data or restart its count. They also toggle the external clock while idle, where a faulty port would start shifting or raise a stray `done`.

// File: rtl/sio_pkg.sv
package sio_pkg;
  typedef enum logic {
    SRC_INTERNAL = 1'b0,
    SRC_EXTERNAL = 1'b1
  } clk_src_e;

  typedef struct packed {
    logic rise;
    logic fall;
  } shift_ev_t;
endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
  parameter int W = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int CHAIN_W = W * STAGES;

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[CHAIN_W-W-1:0], d};
  end

  assign q = chain[CHAIN_W-1 -: W];
endmodule

// File: rtl/sio_edge.sv
module sio_edge
  import sio_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      lvl,
  output shift_ev_t ev
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= lvl;
  end

  always_comb begin
    ev.rise = lvl & ~prev;
    ev.fall = ~lvl & prev;
  end
endmodule

// File: rtl/sio_clkgen.sv
module sio_clkgen
  import sio_pkg::*;
#(
  parameter int CYC_DIV = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run,
  output logic      sck,
  output shift_ev_t ev
);
  localparam int DIV_W = (CYC_DIV > 1) ? $clog2(CYC_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CYC_DIV - 1);

  logic [DIV_W-1:0] div_cnt;
  logic             sck_q;
  logic             tick;

  assign tick = run && (div_cnt == DIV_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      sck_q   <= 1'b1;
    end else if (!run) begin
      div_cnt <= '0;
      sck_q   <= 1'b1;
    end else if (tick) begin
      div_cnt <= '0;
      sck_q   <= ~sck_q;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  always_comb begin
    ev.fall = tick & sck_q;
    ev.rise = tick & ~sck_q;
  end

  assign sck = sck_q;
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter
  import sio_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_byte,
  input  shift_ev_t         ev,
  input  logic              si_s,
  output logic              busy,
  output logic              so,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] shifted;

  assign shifted = {shreg[DATA_W-2:0], si_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      so      <= 1'b0;
      done    <= 1'b0;
      rx_byte <= '0;
      shreg   <= '0;
      bit_cnt <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          shreg   <= tx_byte;
          bit_cnt <= '0;
        end
      end else begin
        if (ev.fall) so <= shreg[DATA_W-1];
        if (ev.rise) begin
          shreg <= shifted;
          if (bit_cnt == LAST_BIT) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            rx_byte <= shifted;
            bit_cnt <= '0;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sio8_port.sv
module sio8_port
  import sio_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CYC_DIV = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_src,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              si,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe,
  output logic              so,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte
);
  clk_src_e  src;
  logic [1:0] pins_s;
  logic       sck_s;
  logic       si_s;
  shift_ev_t  ev_ext;
  shift_ev_t  ev_int;
  shift_ev_t  ev_sel;
  logic       run_int;

  assign src = clk_src_e'(clk_src);

  sio_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sck_i, si}), .q(pins_s)
  );
  assign sck_s = pins_s[1];
  assign si_s  = pins_s[0];

  sio_edge u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(sck_s), .ev(ev_ext)
  );

  assign run_int = busy && (src == SRC_INTERNAL);

  sio_clkgen #(.CYC_DIV(CYC_DIV)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .run(run_int), .sck(sck_o), .ev(ev_int)
  );

  assign ev_sel = (src == SRC_EXTERNAL) ? ev_ext : ev_int;
  assign sck_oe = (src == SRC_INTERNAL);

  sio_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_byte(tx_byte),
    .ev(ev_sel), .si_s(si_s), .busy(busy), .so(so), .done(done),
    .rx_byte(rx_byte)
  );
endmodule

// File: rtl/sio8_chk.sv
module sio8_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_src,
  input logic              sck_o,
  input logic              so,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] rx_byte
);
  // R9: completion pulse lasts a single cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: completion coincides with the end of busy
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R3: received byte only updates on completion
  a_r3_rx_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_byte != $past(rx_byte)) |-> done);

  // R4: with the internal clock, data moves only into a low phase
  a_r4_so_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_src && (so != $past(so))) |-> !sck_o);

  // R5: generated clock idles high
  a_r5_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !clk_src) |-> sck_o);
endmodule

bind sio8_port sio8_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_src(clk_src), .sck_o(sck_o), .so(so),
  .busy(busy), .done(done), .rx_byte(rx_byte)
);

// File: tb/sim_sio8_port.sv
module sim_sio8_port;
  localparam int CYC = 4;
  localparam int HALF = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_src = 1'b0;
  logic       start = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic       si = 1'b0;
  logic       sck_i = 1'b1;
  logic       sck_o, sck_oe, so, busy, done;
  logic [7:0] rx_byte;

  int n_chk = 0;
  int n_bad = 0;
  int donecnt = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sio8_port #(.DATA_W(8), .CYC_DIV(CYC), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .clk_src(clk_src), .start(start),
    .tx_byte(tx_byte), .si(si), .sck_i(sck_i), .sck_o(sck_o),
    .sck_oe(sck_oe), .so(so), .busy(busy), .done(done), .rx_byte(rx_byte)
  );

  // {clk_src, tx, rx}
  localparam logic [16:0] VEC [6] = '{
    {1'b0, 8'hA5, 8'h3C},
    {1'b0, 8'h01, 8'h80},
    {1'b0, 8'hFF, 8'h00},
    {1'b1, 8'h96, 8'h5A},
    {1'b1, 8'h80, 8'h01},
    {1'b0, 8'h00, 8'hFF}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (done) donecnt++;
  endtask

  task automatic xfer_int(input logic [7:0] t, input logic [7:0] r, input bit poke);
    logic [7:0] sent = 8'h00;
    int nrise = 0, nfall = 0, since = 0, n = 0, dn = -1;
    bit phase_ok = 1;
    logic prev;
    string tg;
    tg = poke ? "R8" : "R2";
    donecnt = 0;
    @(negedge clk);
    tx_byte = t; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2", busy, 1);
    chk(sck_oe == 1'b1, "R6", sck_oe, 1);
    prev = sck_o;
    while (dn < 0 && n < 400) begin
      step();
      n++; since++;
      if (poke && n == 20) begin tx_byte = ~t; start = 1'b1; end
      else if (poke && n == 21) begin start = 1'b0; end
      if (sck_o != prev) begin
        if (since != CYC) phase_ok = 0;
        since = 0;
        if (!sck_o) begin
          nfall++;
          si = r[8 - nfall];
        end else begin
          nrise++;
          sent = {sent[6:0], so};
        end
        prev = sck_o;
      end
      if (done) dn = n;
      if (poke && n == 22) chk(busy == 1'b1, "R8", busy, 1);
    end
    chk(phase_ok, "R5", 0, 1);
    chk(dn == 16 * CYC, tg, dn, 16 * CYC);
    chk(nrise == 8 && nfall == 8, tg, nrise, 8);
    chk(sent == t, "R4", sent, t);
    chk(rx_byte == r, "R3", rx_byte, r);
    chk(busy == 1'b0, "R9", busy, 0);
    step();
    chk(done == 1'b0, "R9", done, 0);
    chk(sck_o == 1'b1, "R5", sck_o, 1);
    chk(donecnt == 1, tg, donecnt, 1);
  endtask

  task automatic xfer_ext(input logic [7:0] t, input logic [7:0] r);
    logic [7:0] sent = 8'h00;
    donecnt = 0;
    @(negedge clk);
    tx_byte = t; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(sck_oe == 1'b0, "R6", sck_oe, 0);
    for (int i = 0; i < 8; i++) begin
      sck_i = 1'b0; si = r[7 - i];
      repeat (HALF) step();
      sent = {sent[6:0], so};
      chk(busy == 1'b1 && sck_o == 1'b1, "R6", {busy, sck_o}, 3);
      sck_i = 1'b1;
      repeat (HALF) step();
    end
    chk(donecnt == 1, "R2", donecnt, 1);
    chk(busy == 1'b0, "R9", busy, 0);
    chk(sent == t, "R4", sent, t);
    chk(rx_byte == r, "R3", rx_byte, r);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx0;
    logic so0;
    repeat (3) @(negedge clk);
    chk({sck_o, busy, done, so} == 4'b1000 && rx_byte == 8'h00, "R1",
        {sck_o, busy, done, so, rx_byte}, 12'h800);
    rst_n = 1'b1;
    @(negedge clk);
    chk({sck_o, busy, done, so} == 4'b1000 && rx_byte == 8'h00, "R1",
        {sck_o, busy, done, so, rx_byte}, 12'h800);

    for (int i = 0; i < 6; i++) begin
      clk_src = VEC[i][16];
      repeat (4) @(negedge clk);
      if (clk_src) xfer_ext(VEC[i][15:8], VEC[i][7:0]);
      else         xfer_int(VEC[i][15:8], VEC[i][7:0], 1'b0);
    end

    // start while busy
    clk_src = 1'b0;
    repeat (4) @(negedge clk);
    xfer_int(8'h3C, 8'hC3, 1'b1);

    // external clock edges while idle
    clk_src = 1'b1;
    repeat (4) @(negedge clk);
    rx0 = rx_byte; so0 = so; donecnt = 0;
    for (int k = 0; k < 10; k++) begin
      sck_i = ~sck_i; si = k[0];
      repeat (4) step();
    end
    sck_i = 1'b1;
    repeat (4) step();
    chk(busy == 1'b0, "R7", busy, 0);
    chk(donecnt == 0, "R7", donecnt, 0);
    chk(rx_byte == rx0 && so == so0, "R7", {rx_byte, so}, {rx0, so0});

    xfer_ext(8'h69, 8'hE1);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule